// File: doc/BRIEF.md
# Masked Element-Serial Vector Unit

This block is a small integer vector engine. It keeps a file of eight vector registers of 64 elements each, 64 bits per element. It also keeps a length register that bounds every operation and a 64-bit predicate mask. A controller hands it one instruction at a time over a valid/ready port. The unit then walks the elements from index 0 upward, one per clock. It reads two sources, computes, and writes either the destination element or one bit of the predicate mask.

Arithmetic takes two vector registers, or one vector register and a 64-bit scalar that is applied to every element. Compare instructions fill the predicate mask. An arithmetic instruction flagged as predicated only updates the lanes whose mask bit is set, and all other lanes keep their contents. The length register is set by its own instruction, which takes the scalar operand.

The instruction port obeys valid/ready back-pressure. An instruction transfers on a rising edge where `ins_valid` and `ins_ready` are both high. While an instruction is running, `ins_ready` is low. The sender must then hold `ins_valid` and every instruction field steady until the transfer edge. A combinational element read port, together with the exported length and mask, lets a checker observe all state.

Top module: `vec_serial_unit`

## Requirements
- R1: Reset clears every element of all 8 registers, clears the mask and sets the length to 64. Any element can be read combinationally through `rd_reg`/`rd_idx`.
- R2: A vector instruction processes only elements 0 to length-1. Elements at or above the length are never written.
- R3: Op codes 0, 1 and 2 compute dest[i] = a[i] + b[i], a[i] - b[i] and a[i] * b[i]. Results wrap modulo 2^64, and the product keeps its low 64 bits.
- R4: With `ins_use_scalar` = 1, `ins_scalar` replaces the second vector operand in every element.
- R5: Op code 3 (compare) sets mask bit i to the predicate result for each i below the length. The predicate codes are 0 equal, 1 not equal and 2 signed less-than; code 3 gives 0. Mask bits at or above the length are cleared. No vector register changes, and `ins_masked` has no effect on a compare.
- R6: With `ins_masked` = 1, an arithmetic instruction writes only the elements whose mask bit is 1. All other elements keep their old value.
- R7: `ins_ready` equals not `busy`. After a vector instruction is accepted, `busy` is high for exactly length cycles, one element per cycle. A held instruction waits and is taken on the edge after `busy` falls.
- R8: Op code 4 sets the length to min(`ins_scalar`, 64) on its transfer edge, with no busy cycle.
- R9: A vector or compare instruction with length 0 is busy for one cycle and changes no register and no mask bit.
- R10: Op codes 5 to 7 are accepted and have no effect on registers, mask or length, with no busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Unit can take an instruction |
| ins_op | input | 3 | Operation code |
| ins_pred | input | 2 | Compare predicate code |
| ins_use_scalar | input | 1 | Second operand is the scalar |
| ins_masked | input | 1 | Predicated write |
| ins_vd | input | 3 | Destination register |
| ins_va | input | 3 | First source register |
| ins_vb | input | 3 | Second source register |
| ins_scalar | input | 64 | Scalar operand, also new length |
| busy | output | 1 | Instruction in progress |
| vl_o | output | 7 | Current length register |
| mask_o | output | 64 | Current predicate mask |
| rd_reg | input | 3 | Check port register select |
| rd_idx | input | 6 | Check port element select |
| rd_data | output | 64 | Check port element value |

## Verification
The bench targets the following corner cases:
- A length of 10 followed by a length of 30 produces a three-step staircase. A unit that ignored the length would flatten it.
- A compare at length 40, run after a compare that set every bit, exposes a unit that leaves stale tail bits.
- A signed less-than against zero on negative values, and a less-than on equal values, catch unsigned or less-or-equal predicates.
- Predicated writes to a register preloaded with a known value show whether unselected lanes are kept.
- Zero-length instructions, reserved codes and an over-range length show any unwanted update or a wrong clamp.
- An instruction held during a busy period must read the first instruction's result, so a unit that takes it early computes stale data.

// File: rtl/vsu_pkg.sv
package vsu_pkg;
  parameter int unsigned VSU_NREG  = 8;
  parameter int unsigned VSU_NELEM = 64;
  parameter int unsigned VSU_EW    = 64;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_MUL   = 3'd2,
    OP_CMP   = 3'd3,
    OP_SETVL = 3'd4,
    OP_RSV5  = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } vop_e;

  typedef enum logic [1:0] {
    PR_EQ   = 2'd0,
    PR_NE   = 2'd1,
    PR_LT   = 2'd2,
    PR_NONE = 2'd3
  } vpred_e;

  typedef struct packed {
    vop_e   op;
    vpred_e pred;
    logic   use_sc;
    logic   masked;
  } vctl_t;

  function automatic logic is_vector_op(vop_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) || (op == OP_CMP);
  endfunction
endpackage

// File: rtl/vsu_regfile.sv
module vsu_regfile
  import vsu_pkg::*;
#(
  parameter int unsigned NREG  = VSU_NREG,
  parameter int unsigned NELEM = VSU_NELEM,
  parameter int unsigned EW    = VSU_EW,
  localparam int unsigned RW   = $clog2(NREG),
  localparam int unsigned IW   = $clog2(NELEM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] wreg,
  input  logic [IW-1:0] widx,
  input  logic [EW-1:0] wdata,
  input  logic [RW-1:0] ra_reg,
  input  logic [IW-1:0] ra_idx,
  input  logic [RW-1:0] rb_reg,
  input  logic [IW-1:0] rb_idx,
  input  logic [RW-1:0] rc_reg,
  input  logic [IW-1:0] rc_idx,
  output logic [EW-1:0] ra_data,
  output logic [EW-1:0] rb_data,
  output logic [EW-1:0] rc_data
);
  logic [EW-1:0] store [NREG][NELEM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        for (int e = 0; e < NELEM; e++) begin
          store[r][e] <= '0;
        end
      end
    end else if (we) begin
      store[wreg][widx] <= wdata;
    end
  end

  assign ra_data = store[ra_reg][ra_idx];
  assign rb_data = store[rb_reg][rb_idx];
  assign rc_data = store[rc_reg][rc_idx];
endmodule

// File: rtl/vsu_alu.sv
module vsu_alu
  import vsu_pkg::*;
#(
  parameter int unsigned EW = VSU_EW
) (
  input  vop_e          op,
  input  vpred_e        pred,
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  output logic [EW-1:0] res,
  output logic          cmp_bit
);
  always_comb begin
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_MUL:  res = a * b;
      default: res = a;
    endcase
  end

  always_comb begin
    case (pred)
      PR_EQ:   cmp_bit = (a == b);
      PR_NE:   cmp_bit = (a != b);
      PR_LT:   cmp_bit = ($signed(a) < $signed(b));
      default: cmp_bit = 1'b0;
    endcase
  end
endmodule

// File: rtl/vsu_ctrl.sv
module vsu_ctrl
  import vsu_pkg::*;
#(
  parameter int unsigned NREG  = VSU_NREG,
  parameter int unsigned NELEM = VSU_NELEM,
  parameter int unsigned EW    = VSU_EW,
  localparam int unsigned RW   = $clog2(NREG),
  localparam int unsigned IW   = $clog2(NELEM),
  localparam int unsigned LW   = $clog2(NELEM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  vctl_t            in_ctl,
  input  logic [RW-1:0]    in_vd,
  input  logic [RW-1:0]    in_va,
  input  logic [RW-1:0]    in_vb,
  input  logic [EW-1:0]    in_sc,
  input  logic             cmp_bit,
  output logic             busy,
  output vctl_t            cur_ctl,
  output logic [RW-1:0]    cur_vd,
  output logic [RW-1:0]    cur_va,
  output logic [RW-1:0]    cur_vb,
  output logic [EW-1:0]    cur_sc,
  output logic [IW-1:0]    idx,
  output logic [LW-1:0]    vl,
  output logic [NELEM-1:0] mask,
  output logic             we
);
  function automatic logic [NELEM-1:0] below_len(logic [LW-1:0] n);
    logic [NELEM-1:0] m;
    for (int i = 0; i < NELEM; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  logic busy_q;
  logic [IW-1:0] idx_q;
  logic [LW-1:0] vl_q;
  logic [NELEM-1:0] mask_q;
  vctl_t ctl_q;
  logic [RW-1:0] vd_q, va_q, vb_q;
  logic [EW-1:0] sc_q;
  logic accept, last, elem_active, mask_we;

  assign ins_ready   = !busy_q;
  assign accept      = ins_valid && ins_ready;
  assign last        = (vl_q == '0) || (LW'(idx_q) == vl_q - 1'b1);
  assign elem_active = busy_q && (vl_q != '0);
  assign mask_we     = elem_active && (ctl_q.op == OP_CMP);
  assign we          = elem_active && (ctl_q.op != OP_CMP) && (!ctl_q.masked || mask_q[idx_q]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      vl_q   <= LW'(NELEM);
      mask_q <= '0;
      ctl_q  <= '{op: OP_ADD, pred: PR_EQ, use_sc: 1'b0, masked: 1'b0};
      vd_q   <= '0;
      va_q   <= '0;
      vb_q   <= '0;
      sc_q   <= '0;
    end else if (accept) begin
      if (in_ctl.op == OP_SETVL) begin
        if (in_sc > EW'(NELEM)) vl_q <= LW'(NELEM);
        else                    vl_q <= in_sc[LW-1:0];
      end
      if (is_vector_op(in_ctl.op)) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        ctl_q  <= in_ctl;
        vd_q   <= in_vd;
        va_q   <= in_va;
        vb_q   <= in_vb;
        sc_q   <= in_sc;
        if (in_ctl.op == OP_CMP && vl_q != '0) mask_q <= mask_q & below_len(vl_q);
      end
    end else if (busy_q) begin
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q + 1'b1;
      if (mask_we) mask_q[idx_q] <= cmp_bit;
    end
  end

  assign busy    = busy_q;
  assign cur_ctl = ctl_q;
  assign cur_vd  = vd_q;
  assign cur_va  = va_q;
  assign cur_vb  = vb_q;
  assign cur_sc  = sc_q;
  assign idx     = idx_q;
  assign vl      = vl_q;
  assign mask    = mask_q;

  // R7: an accepted vector instruction starts a busy period
  a_r7_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_vector_op(in_ctl.op)) |=> busy_q);

  // R7: the latched instruction stays fixed until its last element
  a_r7_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> (busy_q && $stable(ctl_q) && $stable(vd_q) && $stable(sc_q)));

  // R2: no element at or beyond the length is touched
  a_r2_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (we || mask_we) |-> (LW'(idx_q) < vl_q));

  // R9: zero length finishes in one cycle without a mask change
  a_r9_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && vl_q == '0) |=> (!busy_q && $stable(mask_q)));

  // R5: a completed compare leaves no mask bit set at or above the length
  a_r5_tail_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && last && ctl_q.op == OP_CMP && vl_q != '0) |=> ((mask_q & ~below_len(vl_q)) == '0));

  // R6: arithmetic never disturbs the mask
  a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ctl_q.op != OP_CMP) |=> $stable(mask_q));

  // R8: the length never exceeds the element count
  a_r8_len_limit: assert property (@(posedge clk) disable iff (!rst_n)
    vl_q <= LW'(NELEM));
endmodule

// File: rtl/vec_serial_unit.sv
module vec_serial_unit
  import vsu_pkg::*;
#(
  parameter int unsigned NREG  = VSU_NREG,
  parameter int unsigned NELEM = VSU_NELEM,
  parameter int unsigned EW    = VSU_EW,
  localparam int unsigned RW   = $clog2(NREG),
  localparam int unsigned IW   = $clog2(NELEM),
  localparam int unsigned LW   = $clog2(NELEM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [2:0]       ins_op,
  input  logic [1:0]       ins_pred,
  input  logic             ins_use_scalar,
  input  logic             ins_masked,
  input  logic [RW-1:0]    ins_vd,
  input  logic [RW-1:0]    ins_va,
  input  logic [RW-1:0]    ins_vb,
  input  logic [EW-1:0]    ins_scalar,
  output logic             busy,
  output logic [LW-1:0]    vl_o,
  output logic [NELEM-1:0] mask_o,
  input  logic [RW-1:0]    rd_reg,
  input  logic [IW-1:0]    rd_idx,
  output logic [EW-1:0]    rd_data
);
  vctl_t in_ctl, cur_ctl;
  logic [RW-1:0] cur_vd, cur_va, cur_vb;
  logic [EW-1:0] cur_sc, a_data, b_data, op_b, alu_res;
  logic [IW-1:0] idx;
  logic we, cmp_bit;

  always_comb begin
    in_ctl.op     = vop_e'(ins_op);
    in_ctl.pred   = vpred_e'(ins_pred);
    in_ctl.use_sc = ins_use_scalar;
    in_ctl.masked = ins_masked;
  end

  vsu_ctrl #(.NREG(NREG), .NELEM(NELEM), .EW(EW)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .in_ctl(in_ctl), .in_vd(ins_vd), .in_va(ins_va), .in_vb(ins_vb), .in_sc(ins_scalar),
    .cmp_bit(cmp_bit), .busy(busy), .cur_ctl(cur_ctl), .cur_vd(cur_vd),
    .cur_va(cur_va), .cur_vb(cur_vb), .cur_sc(cur_sc), .idx(idx), .vl(vl_o),
    .mask(mask_o), .we(we)
  );

  vsu_regfile #(.NREG(NREG), .NELEM(NELEM), .EW(EW)) i_rf (
    .clk(clk), .rst_n(rst_n), .we(we), .wreg(cur_vd), .widx(idx), .wdata(alu_res),
    .ra_reg(cur_va), .ra_idx(idx), .rb_reg(cur_vb), .rb_idx(idx),
    .rc_reg(rd_reg), .rc_idx(rd_idx),
    .ra_data(a_data), .rb_data(b_data), .rc_data(rd_data)
  );

  assign op_b = cur_ctl.use_sc ? cur_sc : b_data;

  vsu_alu #(.EW(EW)) i_alu (
    .op(cur_ctl.op), .pred(cur_ctl.pred), .a(a_data), .b(op_b),
    .res(alu_res), .cmp_bit(cmp_bit)
  );
endmodule

// File: tb/test_vec_serial_unit.sv
module test_vec_serial_unit;
  import vsu_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 1'b0, ins_ready;
  logic [2:0] ins_op = '0;
  logic [1:0] ins_pred = '0;
  logic ins_use_scalar = 1'b0, ins_masked = 1'b0;
  logic [2:0] ins_vd = '0, ins_va = '0, ins_vb = '0;
  logic [63:0] ins_scalar = '0;
  logic busy;
  logic [6:0] vl_o;
  logic [63:0] mask_o;
  logic [2:0] rd_reg = '0;
  logic [5:0] rd_idx = '0;
  logic [63:0] rd_data;

  vec_serial_unit i_vec_serial_unit (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_op(ins_op), .ins_pred(ins_pred), .ins_use_scalar(ins_use_scalar),
    .ins_masked(ins_masked), .ins_vd(ins_vd), .ins_va(ins_va), .ins_vb(ins_vb),
    .ins_scalar(ins_scalar), .busy(busy), .vl_o(vl_o), .mask_o(mask_o),
    .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [63:0] mv [8][64];
  logic [63:0] mmask;
  int mvl;

  string       q_req [$];
  int          q_kind[$];
  logic [2:0]  q_reg [$];
  int          q_idx [$];
  logic [63:0] q_exp [$];

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(string req, int kind, logic [2:0] r, int i, logic [63:0] e);
    q_req.push_back(req); q_kind.push_back(kind); q_reg.push_back(r);
    q_idx.push_back(i); q_exp.push_back(e);
  endtask

  task automatic push_reg(string req, logic [2:0] r);
    for (int i = 0; i < 64; i++) push(req, 0, r, i, mv[r][i]);
  endtask

  task automatic push_state(string req);
    push(req, 1, '0, 0, mmask);
    push(req, 2, '0, 0, 64'(mvl));
  endtask

  // monitor: pops expected items and compares them with what the unit shows
  initial begin
    forever begin
      @(negedge clk);
      if (q_exp.size() != 0) begin
        string req; int kind; logic [63:0] e;
        req = q_req.pop_front(); kind = q_kind.pop_front();
        rd_reg = q_reg.pop_front(); rd_idx = 6'(q_idx.pop_front());
        e = q_exp.pop_front();
        #1;
        if (kind == 0)      check(req, rd_data, e);
        else if (kind == 1) check(req, mask_o, e);
        else                check(req, 64'(vl_o), e);
      end
    end
  end

  task automatic drain();
    while (q_exp.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic model(logic [2:0] op, logic [1:0] pr, bit us, bit mk,
                       logic [2:0] vd, logic [2:0] va, logic [2:0] vb, logic [63:0] sc);
    logic [63:0] a, b, r;
    if (op == 3'd4) mvl = (sc > 64) ? 64 : int'(sc);
    else if (op <= 3'd2) begin
      for (int i = 0; i < mvl; i++) begin
        a = mv[va][i]; b = us ? sc : mv[vb][i];
        r = (op == 3'd0) ? a + b : (op == 3'd1) ? a - b : a * b;
        if (!mk || mmask[i]) mv[vd][i] = r;
      end
    end else if (op == 3'd3 && mvl != 0) begin
      for (int i = 0; i < 64; i++) begin
        a = mv[va][i]; b = us ? sc : mv[vb][i];
        if (i >= mvl)      mmask[i] = 1'b0;
        else if (pr == 0)  mmask[i] = (a == b);
        else if (pr == 1)  mmask[i] = (a != b);
        else if (pr == 2)  mmask[i] = ($signed(a) < $signed(b));
        else               mmask[i] = 1'b0;
      end
    end
  endtask

  task automatic drive(logic [2:0] op, logic [1:0] pr, bit us, bit mk,
                       logic [2:0] vd, logic [2:0] va, logic [2:0] vb, logic [63:0] sc);
    ins_op = op; ins_pred = pr; ins_use_scalar = us; ins_masked = mk;
    ins_vd = vd; ins_va = va; ins_vb = vb; ins_scalar = sc; ins_valid = 1'b1;
  endtask

  task automatic issue(string req, logic [2:0] op, logic [1:0] pr, bit us, bit mk,
                       logic [2:0] vd, logic [2:0] va, logic [2:0] vb, logic [63:0] sc);
    int cyc, exp_cyc;
    exp_cyc = (op <= 3'd3) ? ((mvl == 0) ? 1 : mvl) : 0;
    drive(op, pr, us, mk, vd, va, vb, sc);
    while (!ins_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    ins_valid = 1'b0;
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
    if (op <= 3'd3 && mvl == 0) check("R9", 64'(cyc), 64'(exp_cyc));
    else                        check("R7", 64'(cyc), 64'(exp_cyc));
    model(op, pr, us, mk, vd, va, vb, sc);
    push_state(req);
    if (op != 3'd4) push_reg(req, vd);
    drain();
  endtask

  initial begin
    for (int r = 0; r < 8; r++) for (int i = 0; i < 64; i++) mv[r][i] = '0;
    mmask = '0; mvl = 64;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R7 idle handshake
    check("R7", 64'(busy), 64'd0);
    check("R7", 64'(ins_ready), 64'd1);
    push_state("R1");
    push_reg("R1", 3'd7);
    drain();

    issue("R4", OP_ADD, 0, 1, 0, 3'd1, 3'd0, 3'd0, 64'd5);
    issue("R8", OP_SETVL, 0, 0, 0, 0, 0, 0, 64'd10);
    issue("R2", OP_ADD, 0, 1, 0, 3'd1, 3'd1, 3'd0, 64'd3);
    issue("R8", OP_SETVL, 0, 0, 0, 0, 0, 0, 64'd64);
    issue("R3", OP_MUL, 0, 0, 0, 3'd2, 3'd1, 3'd1, 64'd0);
    issue("R3", OP_SUB, 0, 1, 0, 3'd3, 3'd2, 3'd0, 64'd100);
    issue("R8", OP_SETVL, 0, 0, 0, 0, 0, 0, 64'd30);
    issue("R2", OP_ADD, 0, 1, 0, 3'd1, 3'd1, 3'd0, 64'd1);
    issue("R8", OP_SETVL, 0, 0, 0, 0, 0, 0, 64'd64);
    issue("R4", OP_ADD, 0, 1, 0, 3'd5, 3'd0, 3'd0, 64'd6);
    // compare fills the mask, then a shorter compare must clear the tail
    issue("R5", OP_CMP, PR_NE, 0, 0, 3'd6, 3'd1, 3'd0, 64'd0);
    issue("R8", OP_SETVL, 0, 0, 0, 0, 0, 0, 64'd40);
    issue("R5", OP_CMP, PR_EQ, 0, 1, 3'd6, 3'd1, 3'd5, 64'd0);
    issue("R8", OP_SETVL, 0, 0, 0, 0, 0, 0, 64'd64);
    issue("R6", OP_ADD, 0, 1, 1, 3'd6, 3'd1, 3'd0, 64'd1000);
    issue("R4", OP_ADD, 0, 1, 0, 3'd7, 3'd0, 3'd0, 64'd77);
    issue("R6", OP_MUL, 0, 0, 1, 3'd7, 3'd1, 3'd2, 64'd0);
    issue("R5", OP_CMP, PR_LT, 0, 0, 3'd7, 3'd1, 3'd5, 64'd0);
    issue("R5", OP_CMP, PR_LT, 0, 0, 3'd7, 3'd3, 3'd0, 64'd0);
    issue("R3", OP_MUL, 0, 1, 0, 3'd4, 3'd1, 3'd0, 64'h4000_0000_0000_0003);
    issue("R3", OP_SUB, 0, 0, 0, 3'd6, 3'd2, 3'd3, 64'd0);
    // zero length
    issue("R8", OP_SETVL, 0, 0, 0, 0, 0, 0, 64'd0);
    issue("R9", OP_ADD, 0, 1, 0, 3'd1, 3'd1, 3'd0, 64'd999);
    issue("R9", OP_CMP, PR_EQ, 0, 0, 3'd1, 3'd1, 3'd1, 64'd0);
    issue("R8", OP_SETVL, 0, 0, 0, 0, 0, 0, 64'd200);
    issue("R10", OP_RSV5, 0, 1, 0, 3'd1, 3'd1, 3'd0, 64'd55);
    issue("R10", OP_RSV7, 0, 1, 0, 3'd2, 3'd2, 3'd0, 64'd9);

    // R7 back-pressure: second instruction held while the first runs
    begin
      drive(OP_ADD, 0, 1, 0, 3'd2, 3'd1, 3'd0, 64'd11);
      @(posedge clk); @(negedge clk);
      drive(OP_SUB, 0, 1, 0, 3'd3, 3'd2, 3'd0, 64'd4);
      check("R7", 64'(ins_ready), 64'd0);
      while (!ins_ready) @(negedge clk);
      @(posedge clk); @(negedge clk);
      ins_valid = 1'b0;
      check("R7", 64'(busy), 64'd1);
      while (busy) @(negedge clk);
      model(OP_ADD, 0, 1, 0, 3'd2, 3'd1, 3'd0, 64'd11);
      model(OP_SUB, 0, 1, 0, 3'd3, 3'd2, 3'd0, 64'd4);
      push_reg("R7", 3'd2);
      push_reg("R7", 3'd3);
      drain();
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule